// File: doc/BRIEF.md
# USART Bit-Clock Generator

This block derives every bit-rate timing pulse that a serial transmitter and receiver need from one system clock. A single programmable down-counter sets the base rate. A small mode machine then turns that base rate into a transmit bit enable, a receiver oversampling enable, a serial clock output for synchronous master operation, and edge strobes taken from an external serial clock in synchronous slave operation.

The mode machine has four states. ST_ASYNC_NORM divides the base rate by 16 for transmit bits. ST_ASYNC_DBL divides it by 8. ST_SYNC_MASTER drives a 50% duty serial clock. ST_SYNC_SLAVE follows a synchronized external clock. Every clock edge decodes the three mode inputs into the next state, and a transition can go from any state to any other. ST_ASYNC_NORM is taken when sync_sel=0 and dbl_speed=0, ST_ASYNC_DBL when sync_sel=0 and dbl_speed=1, ST_SYNC_MASTER when sync_sel=1 and clk_dir_out=1, and ST_SYNC_SLAVE when sync_sel=1 and clk_dir_out=0. A transition into a different state clears the bit-phase counter and the serial clock level.

Top module: `usart_clkgen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all enables and strobes are 0, sclk_out is 0, sclk_oe is 0, and the mode is normal asynchronous.
- R2: The base tick is a one-cycle pulse repeating every divisor+1 cycles. A divisor_wr pulse loads the new divisor and restarts the count at once, so the next tick comes divisor+1 edges after the write edge. The divisor is 0 after reset.
- R3: In normal asynchronous mode (sync_sel=0, dbl_speed=0), rx_sample_en pulses on every base tick, and tx_bit_en pulses on every 16th tick, counted from entry into the mode.
- R4: In double-speed asynchronous mode (sync_sel=0, dbl_speed=1), tx_bit_en pulses on every 8th base tick, and rx_sample_en pulses on every tick.
- R5: In synchronous master mode (sync_sel=1, clk_dir_out=1), sclk_oe is 1 and sclk_out starts at 0 and toggles on each base tick. tx_bit_en and tx_change_stb pulse on the tick that drives sclk_out low, and rx_sample_stb pulses on the tick that drives it high. rx_sample_en stays 0.
- R6: dbl_speed has no effect in either synchronous mode.
- R7: In synchronous slave mode (sync_sel=1, clk_dir_out=0), sclk_oe is 0. sclk_in passes through a two-flop synchronizer. A rising edge gives one rx_sample_stb pulse and a falling edge gives one tx_change_stb pulse together with tx_bit_en. Either pulse appears three clock edges after sclk_in changes. sclk_in must stay stable for at least 4 system clocks between changes.
- R8: In both asynchronous modes, sclk_oe and sclk_out are 0, sclk_in is ignored, and tx_change_stb and rx_sample_stb stay 0.
- R9: tx_change_stb and rx_sample_stb are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | 12 | Baud divisor value |
| divisor_wr | input | 1 | Load divisor and restart the counter |
| sync_sel | input | 1 | 0 asynchronous, 1 synchronous |
| dbl_speed | input | 1 | Double speed, asynchronous modes only |
| clk_dir_out | input | 1 | Synchronous clock direction: 1 master, 0 slave |
| sclk_in | input | 1 | External serial clock |
| tx_bit_en | output | 1 | Transmit bit enable |
| rx_sample_en | output | 1 | Receiver oversample enable |
| sclk_out | output | 1 | Serial clock output |
| sclk_oe | output | 1 | Serial clock output enable |
| tx_change_stb | output | 1 | Synchronous transmit-change strobe |
| rx_sample_stb | output | 1 | Synchronous receive-sample strobe |

## Verification
The counter raises its tick on the edge after it reaches zero, and every enable and strobe is registered from that tick, so a pulse is seen two edges after the count runs out. A change on the mode inputs is latched into the state at the next edge and shapes the outputs one edge later. sclk_oe follows the state after one edge. A change on sclk_in becomes a strobe on the third edge. The bench models each of these delays as a register step in a behavioural model that updates on every rising edge. It compares all six outputs at each falling edge, where every output is settled, and it changes inputs only at falling edges.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;
    typedef enum logic [1:0] {
        ST_ASYNC_NORM  = 2'd0,
        ST_ASYNC_DBL   = 2'd1,
        ST_SYNC_MASTER = 2'd2,
        ST_SYNC_SLAVE  = 2'd3
    } clk_mode_e;
endpackage

// File: rtl/usart_baud_gen.sv
module usart_baud_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_in,
    input  logic             div_wr,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= '0;
            tick  <= 1'b0;
        end else if (div_wr) begin
            div_q <= div_in;
            cnt_q <= div_in;
            tick  <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q <= div_q;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q - DIV_W'(1);
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/usart_edge_sync.sv
module usart_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sh[i] <= 1'b0;
                else        sh[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sh[i] <= 1'b0;
                else        sh[i] <= sh[i-1];
            end
        end
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/usart_clk_fsm.sv
module usart_clk_fsm
    import usart_clkgen_pkg::*;
#(
    parameter int NORM_RATIO = 16,
    parameter int DBL_RATIO  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_sel,
    input  logic dbl_speed,
    input  logic clk_dir_out,
    input  logic baud_tick,
    input  logic ext_rise,
    input  logic ext_fall,
    output logic tx_bit_en,
    output logic rx_sample_en,
    output logic tx_change_stb,
    output logic rx_sample_stb,
    output logic sclk_out,
    output logic sclk_oe
);
    localparam int PRE_W = $clog2(NORM_RATIO);
    localparam logic [PRE_W-1:0] NORM_MASK = PRE_W'(NORM_RATIO - 1);
    localparam logic [PRE_W-1:0] DBL_MASK  = PRE_W'(DBL_RATIO - 1);
    localparam logic [PRE_W-1:0] MSTR_MASK = PRE_W'(1);

    clk_mode_e        state, state_nxt;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             sclk_q;
    logic             mode_change;

    always_comb begin
        if (!sync_sel) state_nxt = dbl_speed   ? ST_ASYNC_DBL   : ST_ASYNC_NORM;
        else           state_nxt = clk_dir_out ? ST_SYNC_MASTER : ST_SYNC_SLAVE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ASYNC_NORM;
        else        state <= state_nxt;
    end

    assign mode_change = (state_nxt != state);

    always_comb begin
        unique case (state)
            ST_ASYNC_NORM:  mask = NORM_MASK;
            ST_ASYNC_DBL:   mask = DBL_MASK;
            ST_SYNC_MASTER: mask = MSTR_MASK;
            ST_SYNC_SLAVE:  mask = MSTR_MASK;
            default:        mask = NORM_MASK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q         <= '0;
            sclk_q        <= 1'b0;
            tx_bit_en     <= 1'b0;
            rx_sample_en  <= 1'b0;
            tx_change_stb <= 1'b0;
            rx_sample_stb <= 1'b0;
        end else begin
            if (mode_change) begin
                pre_q  <= '0;
                sclk_q <= 1'b0;
            end else if (baud_tick) begin
                pre_q <= pre_q + PRE_W'(1);
                if (state == ST_SYNC_MASTER) sclk_q <= ~sclk_q;
            end
            unique case (state)
                ST_ASYNC_NORM, ST_ASYNC_DBL: begin
                    tx_bit_en     <= baud_tick && ((pre_q & mask) == mask);
                    rx_sample_en  <= baud_tick;
                    tx_change_stb <= 1'b0;
                    rx_sample_stb <= 1'b0;
                end
                ST_SYNC_MASTER: begin
                    tx_bit_en     <= baud_tick && ((pre_q & mask) == mask);
                    rx_sample_en  <= 1'b0;
                    tx_change_stb <= baud_tick && sclk_q;
                    rx_sample_stb <= baud_tick && !sclk_q;
                end
                ST_SYNC_SLAVE: begin
                    tx_bit_en     <= ext_fall;
                    rx_sample_en  <= 1'b0;
                    tx_change_stb <= ext_fall;
                    rx_sample_stb <= ext_rise;
                end
                default: begin
                    tx_bit_en     <= 1'b0;
                    rx_sample_en  <= 1'b0;
                    tx_change_stb <= 1'b0;
                    rx_sample_stb <= 1'b0;
                end
            endcase
        end
    end

    assign sclk_out = sclk_q;
    assign sclk_oe  = (state == ST_SYNC_MASTER);
endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen #(
    parameter int DIV_W       = 12,
    parameter int NORM_RATIO  = 16,
    parameter int DBL_RATIO   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             divisor_wr,
    input  logic             sync_sel,
    input  logic             dbl_speed,
    input  logic             clk_dir_out,
    input  logic             sclk_in,
    output logic             tx_bit_en,
    output logic             rx_sample_en,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             tx_change_stb,
    output logic             rx_sample_stb
);
    logic baud_tick;
    logic ext_rise;
    logic ext_fall;

    usart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_in (divisor),
        .div_wr (divisor_wr),
        .tick   (baud_tick)
    );

    usart_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sclk_in),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    usart_clk_fsm #(.NORM_RATIO(NORM_RATIO), .DBL_RATIO(DBL_RATIO)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_sel      (sync_sel),
        .dbl_speed     (dbl_speed),
        .clk_dir_out   (clk_dir_out),
        .baud_tick     (baud_tick),
        .ext_rise      (ext_rise),
        .ext_fall      (ext_fall),
        .tx_bit_en     (tx_bit_en),
        .rx_sample_en  (rx_sample_en),
        .tx_change_stb (tx_change_stb),
        .rx_sample_stb (rx_sample_stb),
        .sclk_out      (sclk_out),
        .sclk_oe       (sclk_oe)
    );
endmodule

// File: rtl/usart_clkgen_chk.sv
module usart_clkgen_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] divisor,
    input logic             divisor_wr,
    input logic             sync_sel,
    input logic             dbl_speed,
    input logic             clk_dir_out,
    input logic             sclk_in,
    input logic             tx_bit_en,
    input logic             rx_sample_en,
    input logic             sclk_out,
    input logic             sclk_oe,
    input logic             tx_change_stb,
    input logic             rx_sample_stb
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_change_stb && rx_sample_stb));

    assert_sclk_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_out |-> sclk_oe);

    assert_async_no_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && !$past(sync_sel)) |-> !sclk_oe);

    assert_slave_no_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && $past(sync_sel) && !$past(clk_dir_out)) |-> !sclk_oe);

    assert_master_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && $past(sync_sel) && $past(clk_dir_out)) |-> sclk_oe);

    assert_rx_async_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && rx_sample_en) |-> !$past(sync_sel, 2));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!tx_bit_en && !rx_sample_en && !sclk_out && !tx_change_stb && !rx_sample_stb));
endmodule

bind usart_clkgen usart_clkgen_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/usart_clkgen_bench.sv
module usart_clkgen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] divisor = '0;
    logic        divisor_wr = 1'b0;
    logic        sync_sel = 1'b0;
    logic        dbl_speed = 1'b0;
    logic        clk_dir_out = 1'b0;
    logic        sclk_in = 1'b0;
    logic        tx_bit_en, rx_sample_en, sclk_out, sclk_oe, tx_change_stb, rx_sample_stb;

    usart_clkgen u_usart_clkgen (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .divisor_wr(divisor_wr),
        .sync_sel(sync_sel), .dbl_speed(dbl_speed), .clk_dir_out(clk_dir_out),
        .sclk_in(sclk_in), .tx_bit_en(tx_bit_en), .rx_sample_en(rx_sample_en),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .tx_change_stb(tx_change_stb),
        .rx_sample_stb(rx_sample_stb)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string ph = "R1";
    bit    cmp_on = 0;
    bit    done = 0;

    int m_cnt, m_div, m_tick, m_mode, m_pre, m_sclk, s1, s2, s3;
    int e_tx, e_rx, e_sclk, e_oe, e_txs, e_rxs;
    int o_cnt, o_tick, o_mode, o_pre, o_sclk, nm, mask, rise, fall;

    function automatic int decode(logic sy, logic db, logic dr);
        if (!sy) return db ? 1 : 0;
        return dr ? 2 : 3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_div = 0; m_tick = 0; m_mode = 0; m_pre = 0; m_sclk = 0;
            s1 = 0; s2 = 0; s3 = 0;
            e_tx = 0; e_rx = 0; e_sclk = 0; e_oe = 0; e_txs = 0; e_rxs = 0;
        end else begin
            o_cnt = m_cnt; o_tick = m_tick; o_mode = m_mode; o_pre = m_pre; o_sclk = m_sclk;
            rise = (s2 == 1 && s3 == 0) ? 1 : 0;
            fall = (s2 == 0 && s3 == 1) ? 1 : 0;
            nm = decode(sync_sel, dbl_speed, clk_dir_out);
            if (divisor_wr) begin
                m_div = int'(divisor); m_cnt = int'(divisor); m_tick = 0;
            end else if (o_cnt == 0) begin
                m_cnt = m_div; m_tick = 1;
            end else begin
                m_cnt = o_cnt - 1; m_tick = 0;
            end
            mask = (o_mode == 0) ? 15 : (o_mode == 1) ? 7 : 1;
            if (o_mode == 3) e_tx = fall;
            else             e_tx = (o_tick == 1 && ((o_pre & mask) == mask)) ? 1 : 0;
            e_rx  = (o_tick == 1 && o_mode < 2) ? 1 : 0;
            e_txs = (o_mode == 2) ? ((o_tick == 1 && o_sclk == 1) ? 1 : 0) : (o_mode == 3) ? fall : 0;
            e_rxs = (o_mode == 2) ? ((o_tick == 1 && o_sclk == 0) ? 1 : 0) : (o_mode == 3) ? rise : 0;
            if (nm != o_mode) begin
                m_pre = 0; m_sclk = 0;
            end else if (o_tick == 1) begin
                m_pre = (o_pre + 1) % 16;
                if (o_mode == 2) m_sclk = 1 - o_sclk;
            end
            m_mode = nm;
            s3 = s2; s2 = s1; s1 = int'(sclk_in);
            e_sclk = m_sclk;
            e_oe = (m_mode == 2) ? 1 : 0;
        end
    end

    task automatic chk(string req, string name, logic act, int exp);
        checks++;
        if (int'(act) != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", req, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(ph, "tx_bit_en", tx_bit_en, e_tx);
            chk(ph, "rx_sample_en", rx_sample_en, e_rx);
            chk(ph, "sclk_out", sclk_out, e_sclk);
            chk(ph, "sclk_oe", sclk_oe, e_oe);
            chk(ph, "tx_change_stb", tx_change_stb, e_txs);
            chk(ph, "rx_sample_stb", rx_sample_stb, e_rxs);
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_div(int d);
        @(negedge clk);
        divisor = 12'(d);
        divisor_wr = 1'b1;
        @(negedge clk);
        divisor_wr = 1'b0;
    endtask

    task automatic toggle_ext(int n, int half);
        for (int i = 0; i < n; i++) begin
            run(half);
            sclk_in = ~sclk_in;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        run(5);
        // R1: outputs idle while reset is held
        chk("R1", "tx_bit_en", tx_bit_en, 0);
        chk("R1", "rx_sample_en", rx_sample_en, 0);
        chk("R1", "sclk_out", sclk_out, 0);
        chk("R1", "sclk_oe", sclk_oe, 0);
        chk("R1", "tx_change_stb", tx_change_stb, 0);
        chk("R1", "rx_sample_stb", rx_sample_stb, 0);
        rst_n = 1'b1;
        cmp_on = 1;
        run(40);
        ph = "R2";
        wr_div(3);
        run(97);
        wr_div(5);
        run(4);
        wr_div(2);
        run(60);
        wr_div(0);
        run(40);
        ph = "R3";
        wr_div(1);
        run(200);
        ph = "R4";
        dbl_speed = 1'b1;
        run(200);
        ph = "R5";
        dbl_speed = 1'b0;
        sync_sel = 1'b1;
        clk_dir_out = 1'b1;
        run(100);
        wr_div(4);
        run(7);
        wr_div(2);
        run(80);
        ph = "R6";
        dbl_speed = 1'b1;
        run(100);
        ph = "R7";
        clk_dir_out = 1'b0;
        toggle_ext(30, 10);
        dbl_speed = 1'b0;
        toggle_ext(20, 7);
        ph = "R8";
        sync_sel = 1'b0;
        toggle_ext(20, 6);
        dbl_speed = 1'b1;
        toggle_ext(20, 5);
        ph = "R9";
        sync_sel = 1'b1;
        toggle_ext(40, 4);
        clk_dir_out = 1'b1;
        wr_div(0);
        run(50);
        finish_run();
    end
endmodule